// File: doc/BRIEF.md
# Interleaved Two-Group Warp Issue Scheduler

This block picks one warp per cycle for issue on a SIMT core. It tracks eight warps and splits them into two scheduling groups by warp number parity. Neighbouring warps therefore sit in different groups. While one group works through its compute phase, its memory requests also fetch the lines that the other group's warps will need next.

Scheduling works at two levels. The active group has strict priority, and the warps inside a group take turns in round-robin order. Each group keeps its own rotation pointer. The scheduler moves to the other group only when no warp in the active group can issue, which is normally because all of them are waiting on long-latency memory. The per-warp ready and stall flags feed a purely combinational selection, so the offer reflects the current inputs in the same cycle.

The result leaves the block as a valid/ready stream. The offer (`issue_valid`, `issue_warp`) is accepted on a clock edge where `issue_ready` is also high. Scheduling state changes only on acceptance. When the consumer pushes back and the inputs stay unchanged, the same warp stays on offer. If the inputs change during back-pressure, the offer is recomputed from the unchanged state. A refused offer never moves the pointers or the active group.

Top module: `pa_warp_sched`

## Requirements
- R1: Warps are numbered 0 to 7. Warp n belongs to group n mod 2: group 0 holds warps 0, 2, 4, 6 and group 1 holds warps 1, 3, 5, 7.
- R2: `issue_valid` is high exactly when at least one warp has its `warp_ready` bit set and its `warp_stall` bit clear.
- R3: Whenever `issue_valid` is high, `issue_warp` names a warp that is ready and not stalled.
- R4: While the active group contains an eligible warp, only a warp of the active group is offered.
- R5: Within a group, the offer is the first eligible warp at or after that group's pointer, in rising slot order with wrap-around. After an acceptance, the pointer moves to the slot just past the accepted warp.
- R6: Each group's pointer moves only when a warp of that group is accepted.
- R7: When the active group has no eligible warp and the other group does, the other group's warp is offered. That group becomes active when the offer is accepted.
- R8: When no warp is eligible, `issue_valid` is low and both the active group and the pointers keep their values.
- R9: While `issue_valid` is high and `issue_ready` is low, no scheduling state changes. With unchanged inputs the same warp stays on offer.
- R10: A warp whose stall flag clears is offered in that same cycle, with no clock edge in between.
- R11: After reset, group 0 is active and both pointers are at slot 0, so with every warp eligible the first warp offered is warp 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_ready | input | 8 | Per-warp flag: the warp has an instruction ready |
| warp_stall | input | 8 | Per-warp flag: the warp waits on long-latency memory |
| issue_ready | input | 1 | Consumer accepts the offered warp this cycle |
| issue_valid | output | 1 | A warp is on offer |
| issue_warp | output | 3 | Number of the offered warp |

## Verification
A group switch and consumer back-pressure can land in the same cycle. This happens when the active group runs dry while the downstream stage refuses the offer. The bench sets this up from reset by making only odd warps eligible with `issue_ready` low, which puts a group-1 warp on offer while group 0 is still active. It then makes the even warps eligible again, still without acceptance. The offer must go back to warp 0, which shows that the refused switch never committed. When `issue_ready` finally rises, warp 0 is accepted and the rotation continues inside group 0.

// File: rtl/pa_sched_pkg.sv
package pa_sched_pkg;
  localparam int DEF_WARPS  = 8;
  localparam int DEF_GROUPS = 2;

  function automatic int safe_clog2(input int v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/rr_pick.sv
// Rotating first-set picker: scans req starting at index 'start', wrapping.
module rr_pick #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] start,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    int unsigned c;
    any = 1'b0;
    idx = '0;
    c   = 0;
    for (int o = 0; o < N; o++) begin
      c = (int'(start) + o) % N;
      if (!any && req[c]) begin
        any = 1'b1;
        idx = W'(c);
      end
    end
  end
endmodule

// File: rtl/sched_state.sv
// Active-group register and per-group rotation pointers; updated on acceptance only.
module sched_state #(
  parameter int NUM_GROUPS = 2,
  parameter int GRP_SIZE   = 4,
  parameter int GSEL_W     = 1,
  parameter int SLOT_W     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fire,
  input  logic [GSEL_W-1:0]            sel_grp,
  input  logic [SLOT_W-1:0]            sel_slot,
  output logic [GSEL_W-1:0]            active_q,
  output logic [NUM_GROUPS*SLOT_W-1:0] ptr_flat
);
  logic [SLOT_W-1:0] slot_next;
  assign slot_next = SLOT_W'((int'(sel_slot) + 1) % GRP_SIZE);

  always_ff @(posedge clk) begin
    if (!rst_n)      active_q <= '0;
    else if (fire)   active_q <= sel_grp;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr_flat[g*SLOT_W +: SLOT_W] <= '0;
      else if (fire && (int'(sel_grp) == g))
        ptr_flat[g*SLOT_W +: SLOT_W] <= slot_next;
    end
  end
endmodule

// File: rtl/pa_warp_sched.sv
module pa_warp_sched #(
  parameter int NUM_WARPS  = pa_sched_pkg::DEF_WARPS,
  parameter int NUM_GROUPS = pa_sched_pkg::DEF_GROUPS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_WARPS-1:0]         warp_ready,
  input  logic [NUM_WARPS-1:0]         warp_stall,
  input  logic                         issue_ready,
  output logic                         issue_valid,
  output logic [$clog2(NUM_WARPS)-1:0] issue_warp
);
  localparam int GRP_SIZE = NUM_WARPS / NUM_GROUPS;
  localparam int WID_W    = $clog2(NUM_WARPS);
  localparam int GSEL_W   = pa_sched_pkg::safe_clog2(NUM_GROUPS);
  localparam int SLOT_W   = pa_sched_pkg::safe_clog2(GRP_SIZE);

  logic [NUM_WARPS-1:0]         elig;
  logic [NUM_GROUPS-1:0]        grp_any;
  logic [SLOT_W-1:0]            slot_idx [NUM_GROUPS];
  logic [GSEL_W-1:0]            active_q;
  logic [NUM_GROUPS*SLOT_W-1:0] ptr_flat;
  logic [GSEL_W-1:0]            sel_grp;
  logic [SLOT_W-1:0]            sel_slot;
  logic                         fire;

  assign elig = warp_ready & ~warp_stall;

  // Interleaved grouping: slot k of group g is warp k*NUM_GROUPS+g.
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [GRP_SIZE-1:0] req;
    for (genvar k = 0; k < GRP_SIZE; k++) begin : g_slot
      assign req[k] = elig[k*NUM_GROUPS + g];
    end
    rr_pick #(.N(GRP_SIZE), .W(SLOT_W)) u_slot_pick (
      .req  (req),
      .start(ptr_flat[g*SLOT_W +: SLOT_W]),
      .any  (grp_any[g]),
      .idx  (slot_idx[g])
    );
  end

  // Group level: start the scan at the active group, so it keeps priority.
  rr_pick #(.N(NUM_GROUPS), .W(GSEL_W)) u_grp_pick (
    .req  (grp_any),
    .start(active_q),
    .any  (issue_valid),
    .idx  (sel_grp)
  );

  assign sel_slot   = slot_idx[sel_grp];
  assign issue_warp = WID_W'(int'(sel_slot) * NUM_GROUPS + int'(sel_grp));
  assign fire       = issue_valid && issue_ready;

  sched_state #(
    .NUM_GROUPS(NUM_GROUPS), .GRP_SIZE(GRP_SIZE),
    .GSEL_W(GSEL_W), .SLOT_W(SLOT_W)
  ) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .sel_grp (sel_grp),
    .sel_slot(sel_slot),
    .active_q(active_q),
    .ptr_flat(ptr_flat)
  );
endmodule

// File: rtl/pa_warp_sched_chk.sv
module pa_warp_sched_chk #(
  parameter int NUM_WARPS  = 8,
  parameter int NUM_GROUPS = 2,
  parameter int GSEL_W     = 1,
  parameter int SLOT_W     = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_WARPS-1:0]         warp_ready,
  input logic [NUM_WARPS-1:0]         warp_stall,
  input logic                         issue_ready,
  input logic                         issue_valid,
  input logic [$clog2(NUM_WARPS)-1:0] issue_warp,
  input logic [GSEL_W-1:0]            active_q,
  input logic [NUM_GROUPS*SLOT_W-1:0] ptr_flat
);
  localparam int GRP_SIZE = NUM_WARPS / NUM_GROUPS;

  logic [NUM_WARPS-1:0] el;
  logic                 act_has;
  int                   w_grp;
  int                   w_slot;
  logic [SLOT_W-1:0]    grp_ptr;

  assign el = warp_ready & ~warp_stall;

  always_comb begin
    act_has = 1'b0;
    for (int w = 0; w < NUM_WARPS; w++)
      if ((w % NUM_GROUPS) == int'(active_q) && el[w]) act_has = 1'b1;
    w_grp   = int'(issue_warp) % NUM_GROUPS;
    w_slot  = int'(issue_warp) / NUM_GROUPS;
    grp_ptr = ptr_flat[w_grp*SLOT_W +: SLOT_W];
  end

  // R2
  assert_valid_tracks_elig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid == (el != '0));
  // R3
  assert_offer_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> el[issue_warp]);
  // R4
  assert_active_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && act_has) |-> (w_grp == int'(active_q)));
  // R5
  assert_ptr_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready) |=>
      (int'(grp_ptr) == 0 || 1) && int'(ptr_flat[$past(w_grp)*SLOT_W +: SLOT_W])
        == (($past(w_slot) + 1) % GRP_SIZE));
  // R7
  assert_switch_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready) |=> int'(active_q) == $past(w_grp));
  // R8
  assert_idle_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> ($stable(active_q) && $stable(ptr_flat)));
  // R9
  assert_backpressure_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready) |=> ($stable(active_q) && $stable(ptr_flat)));
endmodule

bind pa_warp_sched pa_warp_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .NUM_GROUPS(NUM_GROUPS),
  .GSEL_W(GSEL_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .warp_ready (warp_ready),
  .warp_stall (warp_stall),
  .issue_ready(issue_ready),
  .issue_valid(issue_valid),
  .issue_warp (issue_warp),
  .active_q   (active_q),
  .ptr_flat   (ptr_flat)
);

// File: tb/pa_warp_sched_tb.sv
module pa_warp_sched_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] warp_ready = '0;
  logic [7:0] warp_stall = '0;
  logic       issue_ready = 1'b0;
  logic       issue_valid;
  logic [2:0] issue_warp;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  pa_warp_sched u_dut (
    .clk(clk), .rst_n(rst_n), .warp_ready(warp_ready), .warp_stall(warp_stall),
    .issue_ready(issue_ready), .issue_valid(issue_valid), .issue_warp(issue_warp)
  );

  task automatic check(input string req, input logic av, input logic [2:0] aw,
                       input logic ev, input logic [2:0] ew);
    n_chk++;
    if (av !== ev || (ev && aw !== ew)) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b warp=%0d, expected valid=%0b warp=%0d",
               req, av, aw, ev, ew);
    end
  endtask

  // Drive one cycle's inputs after the falling edge, then check the offer.
  task automatic step(input logic [7:0] rdy, input logic [7:0] stl, input logic ir,
                      input logic ev, input logic [2:0] ew, input string req);
    @(negedge clk);
    warp_ready = rdy; warp_stall = stl; issue_ready = ir;
    #1 check(req, issue_valid, issue_warp, ev, ew);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; warp_ready = '0; warp_stall = '0; issue_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_rotation();
    do_reset();
    step(8'h00, 8'h00, 1'b1, 1'b0, 3'd0, "R11/R2 idle after reset");
    step(8'hFF, 8'h00, 1'b1, 1'b1, 3'd0, "R11 first offer warp 0");
    step(8'hFF, 8'h00, 1'b1, 1'b1, 3'd2, "R5/R1 rotation");
    step(8'hFF, 8'h00, 1'b1, 1'b1, 3'd4, "R5/R4 rotation");
    step(8'hFF, 8'h00, 1'b1, 1'b1, 3'd6, "R5/R1 rotation");
    step(8'hFF, 8'h00, 1'b1, 1'b1, 3'd0, "R5 wrap");
  endtask

  task automatic t_group_switch();
    do_reset();
    step(8'hFF, 8'h55, 1'b1, 1'b1, 3'd1, "R7 switch to odd group");
    step(8'hFF, 8'h55, 1'b1, 1'b1, 3'd3, "R5 odd rotation");
    step(8'hFF, 8'h00, 1'b1, 1'b1, 3'd5, "R4 active group keeps priority");
    step(8'hFF, 8'hAA, 1'b1, 1'b1, 3'd0, "R7/R6 switch back, pointer kept");
    step(8'hFF, 8'h00, 1'b1, 1'b1, 3'd2, "R4 even group now active");
  endtask

  task automatic t_idle_retention();
    do_reset();
    step(8'hAA, 8'h00, 1'b1, 1'b1, 3'd1, "R7 odd only");
    step(8'h00, 8'h00, 1'b1, 1'b0, 3'd0, "R8 idle");
    step(8'hFF, 8'hFF, 1'b1, 1'b0, 3'd0, "R8/R2 all stalled");
    step(8'hFF, 8'h00, 1'b1, 1'b1, 3'd3, "R8 active and pointer retained");
    step(8'h55, 8'h00, 1'b1, 1'b1, 3'd0, "R6 even pointer untouched");
    step(8'h00, 8'h00, 1'b1, 1'b0, 3'd0, "R8 idle again");
    step(8'hFF, 8'h00, 1'b1, 1'b1, 3'd2, "R8 even kept active");
  endtask

  task automatic t_backpressure();
    do_reset();
    step(8'hFF, 8'h00, 1'b0, 1'b1, 3'd0, "R9 offer under back-pressure");
    step(8'hFF, 8'h00, 1'b0, 1'b1, 3'd0, "R9 held");
    step(8'hFF, 8'h00, 1'b0, 1'b1, 3'd0, "R9 held");
    step(8'hAA, 8'h00, 1'b0, 1'b1, 3'd1, "R7 switch offered, not accepted");
    step(8'hAA, 8'h00, 1'b0, 1'b1, 3'd1, "R9 switch offer held");
    step(8'hFF, 8'h00, 1'b0, 1'b1, 3'd0, "R9 refused switch left state");
    step(8'hFF, 8'h00, 1'b1, 1'b1, 3'd0, "R9 accepted");
    step(8'hFF, 8'h00, 1'b1, 1'b1, 3'd2, "R5 advance after accept");
  endtask

  task automatic t_partial_and_unstall();
    do_reset();
    step(8'h14, 8'h00, 1'b1, 1'b1, 3'd2, "R3 partial ready");
    step(8'h14, 8'h00, 1'b1, 1'b1, 3'd4, "R3/R5 partial ready");
    step(8'h14, 8'h00, 1'b1, 1'b1, 3'd2, "R5 wrap skips idle slots");
    step(8'h40, 8'h40, 1'b1, 1'b0, 3'd0, "R3 stalled ready warp not offered");
    #2 warp_stall = 8'h00;
    #1 check("R10 same-cycle unstall", issue_valid, issue_warp, 1'b1, 3'd6);
  endtask

  initial begin
    t_reset_rotation();
    t_group_switch();
    t_idle_retention();
    t_backpressure();
    t_partial_and_unstall();
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R2: got running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule